// File: doc/BRIEF.md
# Configurable Serial Transmitter with Line Break and Clear-to-Send

This block turns bytes into asynchronous serial frames on one output line. A 31-bit setup word selects the timing and the framing. The low 24 bits give the number of clocks per bit, and the upper bits give the character length, the parity mode, the stop-bit count and a switch that turns off flow control. A producer offers a byte by raising a strobe while the block is not busy. The block reports busy from that cycle until the last stop bit has gone out on the line.

Two inputs act on the line outside of normal framing. A break request drives the line low for as long as it is held, and it abandons any character that is being sent. When the break is released, the line is driven high for one bit time before the block accepts the next byte. An active-low clear-to-send input holds back the start of an accepted character, but it never interrupts a character that has already started. A build parameter can remove the flow-control hardware completely. When it is removed, the clear-to-send input is ignored whatever the setup word says.

Top module: `uart_tx_serial`

## Requirements
- R1: After reset the line is high and busy is low.
- R2: A byte is accepted on a clock edge where send_stb is high and busy is low; busy is high in the next cycle.
- R3: A frame is a low start bit followed by the data bits, least significant bit first. The data bit count comes from cfg[29:28]: 00 gives 8, 01 gives 7, 10 gives 6, 11 gives 5. Each bit lasts cfg[23:0] clocks, and a value of 0 is treated as 1. The start bit begins in the cycle after the acceptance edge.
- R4: When cfg[26] is 1, one parity bit follows the data bits. Its value is set by cfg[25:24]: 00 gives even parity over the data bits sent, 01 gives odd parity, 10 gives a constant 1, 11 gives a constant 0.
- R5: The frame ends with one stop bit (high), or two when cfg[27] is 1. Busy falls exactly frame_bits × bit_time cycles after the acceptance edge, and a new byte can be accepted in that same cycle.
- R6: Framing and bit time are captured at acceptance. A change to cfg after that does not alter the frame in flight.
- R7: With flow control built in (HAS_FLOW_CTL=1) and cfg[30]=0, an accepted character does not start while cts_n is high. During that wait the line stays high and busy stays high. The start bit begins in the cycle after an edge where cts_n is sampled low.
- R8: With cfg[30]=1, cts_n has no effect.
- R9: With HAS_FLOW_CTL=0, cts_n has no effect even when cfg[30]=0.
- R10: A character that has started completes even if cts_n goes high part way through.
- R11: Starting in the cycle after brk is sampled high, the line is low for as long as brk stays high. This abandons any character in progress. Busy is high while brk is high, so a strobe given during a break is not accepted.
- R12: After brk is released, the line and busy stay high for one bit time (cfg[23:0] at release). Then busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 31 | Setup word: bit time, length, parity, stop bits, flow-control off |
| send_stb | input | 1 | Byte offer strobe |
| send_byte | input | 8 | Byte to send |
| brk | input | 1 | Line break request |
| cts_n | input | 1 | Active-low clear-to-send |
| tx_line | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a byte is held, sent, or a break or its recovery is active |

## Verification
The assertions assume that brk, cts_n and send_stb are synchronous to clk, and that cfg is only read at acceptance and at break release. The stimulus changes every input at the falling edge, so each input is stable across the next rising edge. Strobes are only offered after busy has been seen low, except in the one case that deliberately offers a strobe during a break. Random frames keep cts_n low and use short bit times, so that every framing combination fits within the run.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   localparam int CFG_W    = 31;
   localparam int FRAME_W  = 12;
   localparam int B_NOFC   = 30;
   localparam int B_STOP2  = 27;
   localparam int B_PAR_EN = 26;

   typedef enum logic [2:0] {
      S_IDLE, S_HOLD, S_SHIFT, S_BRK, S_GUARD
   } tx_state_e;

   typedef enum logic [1:0] {
      PAR_EVEN = 2'b00, PAR_ODD = 2'b01, PAR_MARK = 2'b10, PAR_SPACE = 2'b11
   } par_kind_e;
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
(
   input  logic [5:0]         fmt,
   input  logic [7:0]         data,
   output logic [FRAME_W-1:0] frame,
   output logic [3:0]         len
);
   logic [3:0] nbits;
   logic       par_en;
   logic       pbit;
   logic [7:0] used;
   par_kind_e  kind;

   always_comb begin
      nbits  = 4'd8 - {2'b00, fmt[5:4]};
      par_en = fmt[2];
      kind   = par_kind_e'(fmt[1:0]);
      for (int i = 0; i < 8; i++)
         used[i] = (i < int'(nbits)) ? data[i] : 1'b0;
      case (kind)
         PAR_EVEN:  pbit = ^used;
         PAR_ODD:   pbit = ~^used;
         PAR_MARK:  pbit = 1'b1;
         default:   pbit = 1'b0;
      endcase
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < int'(nbits)) frame[i+1] = data[i];
      for (int p = 6; p < 10; p++)
         if (par_en && (p == int'(nbits) + 1)) frame[p] = pbit;
      len = 4'd2 + nbits + {3'b000, par_en} + {3'b000, fmt[3]};
   end
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] period,
   output logic         tick
);
   logic [W-1:0] per_q;
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         per_q <= W'(1);
         cnt   <= '0;
      end else if (load) begin
         per_q <= (period == '0) ? W'(1) : period;
         cnt   <= (period == '0) ? '0 : period - W'(1);
      end else if (cnt == '0) begin
         cnt <= per_q - W'(1);
      end else begin
         cnt <= cnt - W'(1);
      end
   end

   assign tick = (cnt == '0);
endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
   import uart_tx_pkg::*;
#(
   parameter int DIV_W        = 24,
   parameter bit HAS_FLOW_CTL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CFG_W-1:0] cfg,
   input  logic             send_stb,
   input  logic [7:0]       send_byte,
   input  logic             brk,
   input  logic             cts_n,
   output logic             tx_line,
   output logic             busy
);
   initial begin
      assert (DIV_W >= 1 && DIV_W <= 24)
         else $error("DIV_W must lie in 1..24");
   end

   tx_state_e          state;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame;
   logic [3:0]         len;
   logic [3:0]         left;
   logic [DIV_W-1:0]   cpb_q;
   logic [DIV_W-1:0]   period_sel;
   logic               hold_off;
   logic               tick;
   logic               load;

   generate
      if (HAS_FLOW_CTL) begin : g_fc
         assign hold_off = cts_n & ~cfg[B_NOFC];
      end else begin : g_nofc
         assign hold_off = 1'b0;
      end
   endgenerate

   uart_tx_framer u_framer (
      .fmt   (cfg[29:24]),
      .data  (send_byte),
      .frame (frame),
      .len   (len)
   );

   assign load = (!brk) && (((state == S_IDLE) && send_stb && !hold_off)
                         || ((state == S_HOLD) && !hold_off)
                         || (state == S_BRK));
   assign period_sel = ((state == S_IDLE) || (state == S_BRK))
                       ? cfg[DIV_W-1:0] : cpb_q;

   uart_tx_baud #(.W(DIV_W)) u_baud (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .period (period_sel),
      .tick   (tick)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= S_IDLE;
         shreg <= '1;
         left  <= '0;
         cpb_q <= '0;
      end else if (brk) begin
         state <= S_BRK;
      end else begin
         case (state)
            S_IDLE: if (send_stb) begin
               shreg <= frame;
               left  <= len;
               cpb_q <= cfg[DIV_W-1:0];
               state <= hold_off ? S_HOLD : S_SHIFT;
            end
            S_HOLD: if (!hold_off) state <= S_SHIFT;
            S_SHIFT: if (tick) begin
               if (left == 4'd1) begin
                  state <= S_IDLE;
                  shreg <= '1;
               end else begin
                  shreg <= {1'b1, shreg[FRAME_W-1:1]};
                  left  <= left - 4'd1;
               end
            end
            S_BRK: begin
               cpb_q <= cfg[DIV_W-1:0];
               state <= S_GUARD;
            end
            S_GUARD: if (tick) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign tx_line = (state == S_BRK)   ? 1'b0 :
                    (state == S_SHIFT) ? shreg[0] : 1'b1;
   assign busy    = (state != S_IDLE) || brk;

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
      (send_stb && !busy) |=> busy);

   assert_bit_stable_R3: assert property (@(posedge clk) disable iff (rst)
      ((state == S_SHIFT) && !tick && !brk) |=> $stable(tx_line));

   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      ((state == S_HOLD) && hold_off && !brk) |=> (tx_line && busy));

   assert_brk_low_R11: assert property (@(posedge clk) disable iff (rst)
      brk |=> !tx_line);

   assert_guard_high_R12: assert property (@(posedge clk) disable iff (rst)
      (!brk && $past(brk)) |=> (tx_line && busy));
endmodule

// File: tb/tb_uart_tx_serial.sv
`timescale 1ns/1ps
module tb_uart_tx_serial;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [30:0] cfg = 31'd4;
   logic        send_stb = 1'b0;
   logic [7:0]  send_byte = 8'h00;
   logic        brk = 1'b0;
   logic        cts_n = 1'b0;
   logic        tx_line, busy, tx_line_nf, busy_nf;
   int          total = 0;
   int          fails = 0;

   always #10 clk = ~clk;

   uart_tx_serial dut (
      .clk(clk), .rst(rst), .cfg(cfg), .send_stb(send_stb),
      .send_byte(send_byte), .brk(brk), .cts_n(cts_n),
      .tx_line(tx_line), .busy(busy));

   uart_tx_serial #(.HAS_FLOW_CTL(1'b0)) dut_nofc (
      .clk(clk), .rst(rst), .cfg(cfg), .send_stb(send_stb),
      .send_byte(send_byte), .brk(brk), .cts_n(cts_n),
      .tx_line(tx_line_nf), .busy(busy_nf));

   function automatic int f_per(logic [30:0] c);
      return (c[23:0] == 24'd0) ? 1 : int'(c[23:0]);
   endfunction

   function automatic int f_len(logic [30:0] c);
      return 2 + (8 - int'(c[29:28])) + int'(c[26]) + int'(c[27]);
   endfunction

   function automatic logic [11:0] f_frame(logic [30:0] c, logic [7:0] d);
      logic [11:0] f;
      int n;
      logic par;
      f = '1;
      f[0] = 1'b0;
      n = 8 - int'(c[29:28]);
      par = 1'b0;
      for (int i = 0; i < n; i++) begin
         f[1+i] = d[i];
         par = par ^ d[i];
      end
      if (c[26]) begin
         case (c[25:24])
            2'b00: f[1+n] = par;
            2'b01: f[1+n] = ~par;
            2'b10: f[1+n] = 1'b1;
            default: f[1+n] = 1'b0;
         endcase
      end
      return f;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // Called right after the edge that starts the start bit.
   // act: 0 none, 1 change cfg at act_at, 2 raise cts_n at act_at
   task automatic capture(logic [30:0] c, logic [7:0] d, int act, int act_at, string tag);
      int p;
      int n;
      logic [11:0] got;
      logic [11:0] expf;
      bit busy_ok;
      p = f_per(c);
      n = f_len(c);
      got = '1;
      expf = f_frame(c, d);
      busy_ok = 1'b1;
      for (int j = 0; j <= n * p; j++) begin
         @(negedge clk);
         if (j == 0) send_stb = 1'b0;
         if (j == act_at && act == 1) cfg = 31'($urandom);
         if (j == act_at && act == 2) cts_n = 1'b1;
         for (int k = 0; k < n; k++)
            if (j == k * p + p / 2) got[k] = tx_line;
         if (j < n * p && !busy) busy_ok = 1'b0;
         if (j == n * p && busy) busy_ok = 1'b0;
      end
      chk(got == expf, {tag, " frame"}, {20'd0, got}, {20'd0, expf});
      chk(busy_ok, "R5 busy span", {31'd0, busy_ok}, 32'd1);
   endtask

   task automatic send(logic [30:0] c, logic [7:0] d, int act, int act_at, string tag);
      while (busy) @(negedge clk);
      cfg = c;
      send_byte = d;
      send_stb = 1'b1;
      @(posedge clk);
      capture(c, d, act, act_at, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : main
      logic [30:0] c;
      bit ok;
      bit nf_ok;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(tx_line && !busy, "R1 reset state", {30'd0, tx_line, busy}, 32'h2);

      // R2 acceptance then R3 8N1
      while (busy) @(negedge clk);
      cfg = 31'd4; send_byte = 8'hA5; send_stb = 1'b1;
      @(posedge clk);
      #1 chk(busy, "R2 busy after accept", {31'd0, busy}, 32'd1);
      capture(31'd4, 8'hA5, 0, -1, "R3 8N1");

      // R3 bit time 0 treated as 1, 7 data bits
      send({1'b0, 2'b01, 4'b0000, 24'd0}, 8'h3C, 0, -1, "R3 len7 per0");
      // R4 parity kinds, R5 two stops and back-to-back
      send({1'b0, 2'b11, 1'b1, 1'b1, 2'b01, 24'd3}, 8'h16, 0, -1, "R4 R5 5O2");
      send({1'b0, 2'b00, 1'b0, 1'b1, 2'b00, 24'd2}, 8'h07, 0, -1, "R4 even");
      send({1'b0, 2'b10, 1'b1, 1'b1, 2'b10, 24'd2}, 8'h00, 0, -1, "R4 mark");
      send({1'b0, 2'b00, 1'b0, 1'b1, 2'b11, 24'd3}, 8'hFF, 0, -1, "R4 space");
      // R6 config change mid frame
      send({1'b0, 2'b00, 1'b0, 1'b1, 2'b01, 24'd4}, 8'h5A, 1, 5, "R6 cfg change");

      // R7 hold while cts_n high, R9 nofc ignores it
      while (busy || busy_nf) @(negedge clk);
      cts_n = 1'b1;
      c = {1'b0, 6'b000000, 24'd3};
      cfg = c; send_byte = 8'hC3; send_stb = 1'b1;
      @(posedge clk);
      ok = 1'b1;
      nf_ok = 1'b1;
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         if (j == 0) begin
            send_stb = 1'b0;
            if (tx_line_nf) nf_ok = 1'b0;
         end
         if (!tx_line || !busy) ok = 1'b0;
      end
      chk(ok, "R7 held while cts_n high", {31'd0, ok}, 32'd1);
      chk(nf_ok, "R9 no flow hardware starts", {31'd0, nf_ok}, 32'd1);
      cts_n = 1'b0;
      @(posedge clk);
      // R7 start after release, R10 completes despite cts_n rising
      capture(c, 8'hC3, 2, 7, "R7 R10 released frame");
      // R8 bit 30 disables flow control (cts_n still high)
      send({1'b1, 6'b000000, 24'd2}, 8'h81, 0, -1, "R8 flow off");
      cts_n = 1'b0;

      // R11 break mid frame, R12 guard
      while (busy || busy_nf) @(negedge clk);
      cfg = 31'd4; send_byte = 8'hFF; send_stb = 1'b1;
      @(posedge clk);
      repeat (6) begin
         @(negedge clk);
         send_stb = 1'b0;
      end
      brk = 1'b1;
      @(negedge clk);
      ok = 1'b1;
      for (int j = 0; j < 15; j++) begin
         @(negedge clk);
         if (tx_line || !busy) ok = 1'b0;
      end
      chk(ok, "R11 line low during break", {31'd0, ok}, 32'd1);
      cfg = 31'd5;
      brk = 1'b0;
      ok = 1'b1;
      for (int j = 0; j <= 5; j++) begin
         @(negedge clk);
         if (j < 5 && (!tx_line || !busy)) ok = 1'b0;
         if (j == 5 && busy) ok = 1'b0;
      end
      chk(ok, "R12 guard bit time", {31'd0, ok}, 32'd1);

      // R11 strobe during break is not accepted
      brk = 1'b1; send_stb = 1'b1; cfg = 31'd3;
      @(negedge clk);
      send_stb = 1'b0;
      chk(busy, "R11 busy during break", {31'd0, busy}, 32'd1);
      brk = 1'b0;
      ok = 1'b1;
      for (int j = 0; j < 12; j++) begin
         @(negedge clk);
         if (!tx_line) ok = 1'b0;
      end
      chk(ok && !busy, "R11 strobe in break ignored", {30'd0, ok, busy}, 32'h2);

      // Random frames: R3 R4 R5
      for (int r = 0; r < 40; r++) begin
         c = {1'($urandom), 6'($urandom), 24'(2 + $urandom % 4)};
         send(c, 8'($urandom), 0, -1, "R3 R4 R5 random");
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule